// File: doc/BRIEF.md
# 6502 Effective Address Generator

This block resolves the operand location for an 8-bit accumulator CPU that uses the 6502 set of addressing modes. A request carries a mode code, the operand bytes that followed the opcode, both index registers and the address of the next instruction. The block answers with a 16-bit effective address, or with the operand byte itself for immediate mode, and marks the answer with a one-cycle `done` pulse. Opcode decode, the ALU, flag logic and write-back all sit outside it.

Most modes need only one adder and finish in the cycle after the request is taken. The three pointer modes read a two-byte little-endian pointer through a synchronous byte-read port that has a fixed one-cycle latency. The read of the high byte is issued in the same cycle that the low byte comes back, so a pointer mode finishes three cycles later than a direct mode. Requests enter on a valid/ready pair. `req_ready` is low while a pointer fetch is in flight. The requester must then hold `req_valid` and every request field steady, and a request waiting in that state is taken in the cycle that `done` reports the earlier result. The result side has no back-pressure: `done` is a single-cycle strobe, and the result outputs keep their value until the next `done`.

Top module: `eaddr_unit`

## Requirements
- R1: After reset `done` and `rd_en` are low and `req_ready` is high.
- R2: Zero-page modes form the address as high byte 0 and low byte equal to the operand (code 3), to operand+X (code 4) or to operand+Y (code 5). Each sum is taken modulo 256, so $FF+1 gives $0000.
- R3: Absolute mode (code 7) forms {second operand byte, first operand byte}, with the first byte as the low half. Codes 8 and 9 add X or Y to that full 16-bit value modulo 65536, so a carry passes into the high byte.
- R4: Relative mode (code 6) outputs `req_pc`, the address of the instruction after the branch, plus the first operand byte read as a signed two's-complement value.
- R5: Immediate mode (code 2) returns the first operand byte on `imm` with `imm_valid`=1 and `ea_valid`=0.
- R6: Implied (code 0), accumulator (code 1) and the unused codes 13 to 15 finish with `ea_valid`=0 and `imm_valid`=0 and make no memory read.
- R7: Indirect mode (code 10) reads the byte at P={op_hi,op_lo} and then the byte at P+1, where the increment carries into the high byte. The output is {byte at P+1, byte at P}.
- R8: Indexed-indirect mode (code 11) reads at {0, op_lo+X} and at {0, op_lo+X+1}, with both sums taken modulo 256. The output is the pointer read, high byte from the second read.
- R9: Indirect-indexed mode (code 12) reads at {0, op_lo} and {0, op_lo+1 mod 256}. The output is that 16-bit pointer plus Y modulo 65536.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. A direct mode raises `done` right after that edge. A pointer mode drives `rd_en` for exactly two cycles after the edge, low-byte address first, and raises `done` after the fourth edge. Returned data is used one cycle after its `rd_en`.
- R11: `req_ready` stays low from the taking of a pointer-mode request until its `done` cycle. A request held meanwhile is taken in that `done` cycle.
- R12: `done` lasts one cycle per request, and `ea` changes only in cycles where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_mode | input | 4 | Addressing-mode code (see R2 to R9) |
| req_op_lo | input | 8 | First operand byte |
| req_op_hi | input | 8 | Second operand byte |
| req_x | input | 8 | X index register |
| req_y | input | 8 | Y index register |
| req_pc | input | 16 | Address of the instruction after the current one |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | One-cycle completion strobe |
| ea | output | 16 | Effective address |
| ea_valid | output | 1 | `ea` holds an address for the last result |
| imm | output | 8 | Immediate operand |
| imm_valid | output | 1 | `imm` holds the operand for the last result |

## Verification
The overlap that matters is the `done` of a pointer-mode request and the taking of the next request, which fall in the same cycle. The bench issues an indirect request and at once holds a zero-page request on `req_valid`. It then checks that `req_ready` stays low for three cycles, that `ea` keeps its old value in those cycles, and that the pointer result appears together with a high `req_ready`. The very next cycle must show the zero-page address. The second overlap is inside a fetch, where the high-byte read is issued while the low byte returns. It is judged by the two logged read addresses and by results built from distinct bytes at the two locations.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    AM_IMP  = 4'd0,
    AM_ACC  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_REL  = 4'd6,
    AM_ABS  = 4'd7,
    AM_ABSX = 4'd8,
    AM_ABSY = 4'd9,
    AM_IND  = 4'd10,
    AM_IZX  = 4'd11,
    AM_IZY  = 4'd12
  } am_e;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_LO   = 2'd1,
    PF_HI   = 2'd2,
    PF_FIN  = 2'd3
  } pf_state_e;
endpackage

// File: rtl/eag_direct_calc.sv
// Single-cycle address arithmetic and pointer setup for the pointer modes.
module eag_direct_calc #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic [3:0]    mode,
  input  logic [DW-1:0] op_lo,
  input  logic [DW-1:0] op_hi,
  input  logic [DW-1:0] x,
  input  logic [DW-1:0] y,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] calc_ea,
  output logic          has_ea,
  output logic          has_imm,
  output logic          need_ptr,
  output logic [AW-1:0] ptr_addr,
  output logic          ptr_in_zp,
  output logic [DW-1:0] post_idx
);
  import eag_pkg::*;
  localparam int PW = AW - DW;
  localparam logic [PW-1:0] ZPAGE = '0;

  logic [DW-1:0] sum_x, sum_y;
  logic [AW-1:0] abs_a, rel_off;

  always_comb begin
    sum_x   = op_lo + x;                 // wraps inside the page
    sum_y   = op_lo + y;
    abs_a   = {op_hi, op_lo};            // low byte came first
    rel_off = {{PW{op_lo[DW-1]}}, op_lo};
  end

  always_comb begin
    calc_ea   = '0;
    has_ea    = 1'b0;
    has_imm   = 1'b0;
    need_ptr  = 1'b0;
    ptr_addr  = '0;
    ptr_in_zp = 1'b0;
    post_idx  = '0;
    case (am_e'(mode))
      AM_IMM:  has_imm = 1'b1;
      AM_ZP:   begin calc_ea = {ZPAGE, op_lo}; has_ea = 1'b1; end
      AM_ZPX:  begin calc_ea = {ZPAGE, sum_x}; has_ea = 1'b1; end
      AM_ZPY:  begin calc_ea = {ZPAGE, sum_y}; has_ea = 1'b1; end
      AM_REL:  begin calc_ea = pc + rel_off;   has_ea = 1'b1; end
      AM_ABS:  begin calc_ea = abs_a;          has_ea = 1'b1; end
      AM_ABSX: begin calc_ea = abs_a + AW'(x); has_ea = 1'b1; end
      AM_ABSY: begin calc_ea = abs_a + AW'(y); has_ea = 1'b1; end
      AM_IND:  begin need_ptr = 1'b1; ptr_addr = abs_a; end
      AM_IZX:  begin
        need_ptr  = 1'b1;
        ptr_addr  = {ZPAGE, sum_x};
        ptr_in_zp = 1'b1;
      end
      AM_IZY:  begin
        need_ptr  = 1'b1;
        ptr_addr  = {ZPAGE, op_lo};
        ptr_in_zp = 1'b1;
        post_idx  = y;
      end
      default: ;                          // implied, accumulator, unused
    endcase
  end
endmodule

// File: rtl/eag_ptr_fetch.sv
// Two-byte pointer fetch; the high read overlaps the low-byte return.
module eag_ptr_fetch #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ptr_addr,
  input  logic          ptr_in_zp,
  input  logic [DW-1:0] post_idx,
  output logic          busy,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          fin,
  output logic [AW-1:0] target
);
  import eag_pkg::*;
  localparam int PW = AW - DW;
  localparam logic [PW-1:0] ZPAGE = '0;

  pf_state_e     st;
  logic [AW-1:0] ptr_q;
  logic          zp_q;
  logic [DW-1:0] idx_q, lo_q, zp_next;
  logic [AW-1:0] hi_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= PF_IDLE;
      ptr_q <= '0;
      zp_q  <= 1'b0;
      idx_q <= '0;
      lo_q  <= '0;
    end else begin
      case (st)
        PF_IDLE: if (start) begin
          st    <= PF_LO;
          ptr_q <= ptr_addr;
          zp_q  <= ptr_in_zp;
          idx_q <= post_idx;
        end
        PF_LO:   st <= PF_HI;
        PF_HI:   begin st <= PF_FIN; lo_q <= rd_data; end
        default: st <= PF_IDLE;
      endcase
    end
  end

  always_comb begin
    zp_next = ptr_q[DW-1:0] + DW'(1);
    hi_addr = zp_q ? {ZPAGE, zp_next} : (ptr_q + AW'(1));
    busy    = (st != PF_IDLE);
    rd_en   = (st == PF_LO) || (st == PF_HI);
    rd_addr = (st == PF_HI) ? hi_addr : ptr_q;
    fin     = (st == PF_FIN);
    target  = {rd_data, lo_q} + AW'(idx_q);
  end
endmodule

// File: rtl/eaddr_unit.sv
module eaddr_unit #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_mode,
  input  logic [DW-1:0]   req_op_lo,
  input  logic [DW-1:0]   req_op_hi,
  input  logic [DW-1:0]   req_x,
  input  logic [DW-1:0]   req_y,
  input  logic [2*DW-1:0] req_pc,
  output logic            rd_en,
  output logic [2*DW-1:0] rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic            done,
  output logic [2*DW-1:0] ea,
  output logic            ea_valid,
  output logic [DW-1:0]   imm,
  output logic            imm_valid
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] calc_ea, ptr_addr, target;
  logic          has_ea, has_imm, need_ptr, ptr_in_zp;
  logic [DW-1:0] post_idx;
  logic          busy, fin, take;

  eag_direct_calc #(.DW(DW), .AW(AW)) u_calc (
    .mode(req_mode), .op_lo(req_op_lo), .op_hi(req_op_hi),
    .x(req_x), .y(req_y), .pc(req_pc),
    .calc_ea(calc_ea), .has_ea(has_ea), .has_imm(has_imm),
    .need_ptr(need_ptr), .ptr_addr(ptr_addr), .ptr_in_zp(ptr_in_zp),
    .post_idx(post_idx)
  );

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  eag_ptr_fetch #(.DW(DW), .AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(take && need_ptr),
    .ptr_addr(ptr_addr), .ptr_in_zp(ptr_in_zp), .post_idx(post_idx),
    .busy(busy), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .fin(fin), .target(target)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      ea        <= '0;
      ea_valid  <= 1'b0;
      imm       <= '0;
      imm_valid <= 1'b0;
    end else begin
      done <= 1'b0;
      if (fin) begin
        done      <= 1'b1;
        ea        <= target;
        ea_valid  <= 1'b1;
        imm_valid <= 1'b0;
      end else if (take && !need_ptr) begin
        done      <= 1'b1;
        ea        <= calc_ea;
        ea_valid  <= has_ea;
        imm_valid <= has_imm;
        if (has_imm) imm <= req_op_lo;
      end
    end
  end
endmodule

// File: rtl/eag_checker.sv
module eag_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [3:0]  req_mode,
  input logic        rd_en,
  input logic [15:0] rd_addr,
  input logic        done,
  input logic [15:0] ea,
  input logic        ea_valid,
  input logic        imm_valid
);
  import eag_pkg::*;
  logic take_zp_ptr, take_direct;
  assign take_zp_ptr = req_valid && req_ready &&
                       (req_mode == AM_IZX || req_mode == AM_IZY);
  assign take_direct = req_valid && req_ready && !(req_mode == AM_IND ||
                       req_mode == AM_IZX || req_mode == AM_IZY);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !done && !rd_en);                                         // R1
  AST_ZP_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
    take_zp_ptr |=> (rd_en && rd_addr[15:8] == 8'h00) ##1
                    (rd_en && rd_addr[15:8] == 8'h00));                   // R8
  AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |=> !rd_en);                                    // R10
  AST_DIRECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_direct |=> done);                                                // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !req_ready);                                                // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(req_valid && req_ready) |=> !done);                         // R12
  AST_EA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(ea));                                               // R12
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(ea_valid && imm_valid));                                   // R5
endmodule

bind eaddr_unit eag_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_mode(req_mode), .rd_en(rd_en), .rd_addr(rd_addr), .done(done),
  .ea(ea), .ea_valid(ea_valid), .imm_valid(imm_valid)
);

// File: tb/sim_eaddr_unit.sv
`timescale 1ns/1ps
module sim_eaddr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_mode = '0;
  logic [7:0]  req_op_lo = '0, req_op_hi = '0, req_x = '0, req_y = '0;
  logic [15:0] req_pc = '0;
  logic        rd_en, done, ea_valid, imm_valid;
  logic [15:0] rd_addr, ea;
  logic [7:0]  rd_data = '0, imm;

  int checks = 0, fails = 0, rd_cnt = 0;
  logic [15:0] rd_a0, rd_a1;
  logic [15:0] g_ea; logic g_eav, g_immv; logic [7:0] g_imm; int g_lat;

  always #4 clk = ~clk;

  eaddr_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_op_lo(req_op_lo), .req_op_hi(req_op_hi),
    .req_x(req_x), .req_y(req_y), .req_pc(req_pc), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .ea(ea),
    .ea_valid(ea_valid), .imm(imm), .imm_valid(imm_valid)
  );

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    logic [7:0] t;
    t = a[15:8] * 8'd37;
    return a[7:0] ^ t ^ 8'hC3;
  endfunction

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem_f(rd_addr);
      if (rd_cnt == 0) rd_a0 <= rd_addr;
      if (rd_cnt == 1) rd_a1 <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic run_req(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [7:0] x, input logic [7:0] y, input logic [15:0] pc);
    @(negedge clk);
    rd_cnt = 0;
    req_mode = m; req_op_lo = lo; req_op_hi = hi; req_x = x; req_y = y; req_pc = pc;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_lat = 1;
    while (!done && g_lat < 10) begin @(negedge clk); g_lat++; end
    g_ea = ea; g_eav = ea_valid; g_imm = imm; g_immv = imm_valid;
  endtask

  task automatic direct_addr(input string rq, input logic [3:0] m, input logic [7:0] lo,
                             input logic [7:0] hi, input logic [7:0] x, input logic [7:0] y,
                             input logic [15:0] pc, input logic [15:0] exp);
    run_req(m, lo, hi, x, y, pc);
    chk(rq, g_ea, exp);
    chk(rq, g_eav, 1);
    chk({rq, " latency R10"}, g_lat, 1);
    chk({rq, " no read"}, rd_cnt, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 rd_en", rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_zero_page;
    direct_addr("R2 zp", 4'd3, 8'h80, 8'h55, 8'h11, 8'h22, 16'h1234, 16'h0080);
    direct_addr("R2 zpx wrap", 4'd4, 8'hFF, 8'h55, 8'h01, 8'h22, 16'h1234, 16'h0000);
    direct_addr("R2 zpy wrap", 4'd5, 8'hF0, 8'h55, 8'h77, 8'h20, 16'h1234, 16'h0010);
  endtask

  task automatic t_absolute;
    direct_addr("R3 abs", 4'd7, 8'h34, 8'h12, 8'h05, 8'h06, 16'h0, 16'h1234);
    direct_addr("R3 absx carry", 4'd8, 8'hFF, 8'h12, 8'h01, 8'h06, 16'h0, 16'h1300);
    direct_addr("R3 absy wrap", 4'd9, 8'hFF, 8'hFF, 8'h09, 8'h02, 16'h0, 16'h0001);
  endtask

  task automatic t_relative;
    direct_addr("R4 back", 4'd6, 8'hFE, 8'h00, 8'h0, 8'h0, 16'h8010, 16'h800E);
    direct_addr("R4 fwd max", 4'd6, 8'h7F, 8'h00, 8'h0, 8'h0, 16'h8010, 16'h808F);
    direct_addr("R4 min", 4'd6, 8'h80, 8'h00, 8'h0, 8'h0, 16'h8010, 16'h7F90);
    direct_addr("R4 page cross", 4'd6, 8'h20, 8'h00, 8'h0, 8'h0, 16'h80F0, 16'h8110);
  endtask

  task automatic t_immediate;
    run_req(4'd2, 8'hA5, 8'h3C, 8'h0, 8'h0, 16'h0);
    chk("R5 imm", g_imm, 8'hA5);
    chk("R5 imm_valid", g_immv, 1);
    chk("R5 ea_valid", g_eav, 0);
    chk("R5 latency", g_lat, 1);
  endtask

  task automatic t_no_operand;
    logic [3:0] codes [3];
    codes[0] = 4'd0; codes[1] = 4'd1; codes[2] = 4'd14;
    for (int i = 0; i < 3; i++) begin
      run_req(codes[i], 8'h10, 8'h20, 8'h1, 8'h2, 16'h4000);
      chk("R6 ea_valid", g_eav, 0);
      chk("R6 imm_valid", g_immv, 0);
      chk("R6 no read", rd_cnt, 0);
      chk("R6 latency", g_lat, 1);
    end
  endtask

  task automatic t_indirect;
    logic [15:0] e;
    e = {mem_f(16'h0300), mem_f(16'h02FF)};
    run_req(4'd10, 8'hFF, 8'h02, 8'h33, 8'h44, 16'h0);
    chk("R7 target", g_ea, e);
    chk("R7 first read", rd_a0, 16'h02FF);
    chk("R7 second read", rd_a1, 16'h0300);
    chk("R10 reads", rd_cnt, 2);
    chk("R10 latency", g_lat, 4);
    chk("R7 ea_valid", g_eav, 1);
  endtask

  task automatic t_pre_index;
    logic [15:0] e;
    e = {mem_f(16'h0000), mem_f(16'h00FF)};
    run_req(4'd11, 8'hFE, 8'h99, 8'h01, 8'h44, 16'h0);
    chk("R8 target", g_ea, e);
    chk("R8 first read", rd_a0, 16'h00FF);
    chk("R8 hi wrap read", rd_a1, 16'h0000);
    chk("R8 latency", g_lat, 4);
  endtask

  task automatic t_post_index;
    logic [15:0] e;
    e = {mem_f(16'h0000), mem_f(16'h00FF)} + 16'h00F0;
    run_req(4'd12, 8'hFF, 8'h99, 8'h05, 8'hF0, 16'h0);
    chk("R9 target", g_ea, e);
    chk("R9 first read", rd_a0, 16'h00FF);
    chk("R9 hi wrap read", rd_a1, 16'h0000);
    e = {mem_f(16'h0041), mem_f(16'h0040)} + 16'h00FF;
    run_req(4'd12, 8'h40, 8'h00, 8'h05, 8'hFF, 16'h0);
    chk("R9 carry target", g_ea, e);
  endtask

  task automatic t_overlap;
    logic [15:0] e, old;
    e = {mem_f(16'h1235), mem_f(16'h1234)};
    @(negedge clk);
    old = ea;
    req_mode = 4'd10; req_op_lo = 8'h34; req_op_hi = 8'h12; req_valid = 1'b1;
    @(negedge clk);
    req_mode = 4'd3; req_op_lo = 8'h5A;
    for (int i = 0; i < 3; i++) begin
      chk("R11 ready low while fetching", req_ready, 0);
      chk("R12 ea held", ea, old);
      chk("R12 no done", done, 0);
      @(negedge clk);
    end
    chk("R11 done with ready", {done, req_ready}, 2'b11);
    chk("R7 overlap target", ea, e);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 queued taken", {done, ea}, {1'b1, 16'h005A});
    @(negedge clk);
    chk("R12 single pulse", done, 0);
    chk("R12 ea kept", ea, 16'h005A);
  endtask

  initial begin
    t_reset();
    t_zero_page();
    t_absolute();
    t_relative();
    t_immediate();
    t_no_operand();
    t_indirect();
    t_pre_index();
    t_post_index();
    t_overlap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule